// File: doc/BRIEF.md
# High-Speed Lane Sync Word Aligner

This block sits behind the double-data-rate capture flops of one high-speed serial data lane. Once the lane state logic reports that the lane is in high-speed mode, the aligner takes two bits per clock and watches the stream for the start-of-burst leader. The transmitter precedes every burst with a stretch of high-speed zeros and then the 8-bit leader `00011101` in transmission order. The aligner ignores the zeros and finds the leader at either bit position of the two-bit capture word. It then freezes that bit position and cuts the rest of the burst into payload bytes, each marked by a one-cycle valid strobe.

A stray one that cannot be the start of the leader marks the burst as corrupt. The aligner raises an error flag and releases nothing until the lane leaves high-speed mode. Dropping the high-speed enable, which happens when the lane returns to the stop state, ends the burst. It clears the lock, the error, any partial byte and the search history, so the next burst is hunted from a clean window.

Top module: `hs_sync_aligner`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `sync_found_o`, `sync_err_o` and `byte_o` are all zero.
- R2: Each clock delivers two bits, with `bits_i[0]` received before `bits_i[1]`. Payload bytes are assembled least-significant bit first, so the first payload bit after the leader appears on `byte_o[0]`.
- R3: High-speed zeros received before the leader raise no flag and produce no valid strobe.
- R4: The leader `00011101`, which has byte value 0xB8 once reassembled, is found whether its last bit arrives on `bits_i[0]` or on `bits_i[1]`. `sync_found_o` rises in the cycle after the clock in which that last bit arrives and stays high until `hs_en_i` drops.
- R5: After the leader, every group of 8 received bits is presented on `byte_o` with `valid_o` high for exactly one cycle. Both are registered at the clock in which the eighth bit arrives.
- R6: `valid_o` is never high in a burst before the leader has been found.
- R7: While hunting, a received one must be completed by the leader within four more bits, which means the 8 bits ending four bits after it must equal 0xB8. Otherwise `sync_err_o` rises in the following cycle and holds until `hs_en_i` drops. No byte of that burst is released, even if a leader follows.
- R8: A cycle with `hs_en_i` low clears `sync_found_o`, `sync_err_o`, `valid_o` and any partial byte. While `hs_en_i` is low, `bits_i` is ignored, and the next burst starts its search from an all-zero history.
- R9: A payload byte equal to 0xB8 is delivered as data and does not disturb the frozen byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte-domain clock, one rising edge per two received bits |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hs_en_i | input | 1 | High while the lane is in high-speed receive mode |
| bits_i | input | 2 | Captured bits of this clock, bit 0 earlier in time |
| byte_o | output | 8 | Aligned payload byte, LSB received first |
| valid_o | output | 1 | One-cycle strobe qualifying `byte_o` |
| sync_found_o | output | 1 | Leader found, byte boundary locked |
| sync_err_o | output | 1 | Burst rejected for a bad pattern before the leader |

## Verification
The assertions assume that `hs_en_i` and `bits_i` are always driven to known values. They also assume that a burst is closed only by lowering `hs_en_i` for at least one clock, never by reset alone. The stimulus holds every input steady across each rising edge and changes it only on the falling edge. It marks the end of every burst with at least one clock of `hs_en_i` low, and while the enable is low it drives ones onto `bits_i` so that ignored data is visible. The stimulus places leaders at both bit positions and includes bursts with no zero leader, a corrupt pre-leader pattern, a burst cut mid-byte and a payload byte equal to the leader value.

// File: rtl/hs_align_pkg.sv
package hs_align_pkg;

  typedef enum logic [1:0] {
    ALN_HUNT = 2'd0,
    ALN_LOCK = 2'd1,
    ALN_DROP = 2'd2
  } aln_state_e;

  // index of the lowest set bit, 0 when none
  function automatic int unsigned lowest_set(input logic [63:0] v);
    int unsigned idx;
    logic        seen;
    idx  = 0;
    seen = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (v[i] && !seen) begin
        idx  = i;
        seen = 1'b1;
      end
    end
    return idx;
  endfunction

endpackage

// File: rtl/hs_align_window.sv
module hs_align_window #(
  parameter int W = 8,
  parameter int P = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic [P-1:0]        bits_i,
  output logic [P-1:0][W-1:0] win_o
);
  localparam int HIST_W = W - 1;
  localparam int EXT_W  = HIST_W + P;

  logic [HIST_W-1:0] hist_q;
  logic [EXT_W-1:0]  ext;

  // oldest bit at index 0
  assign ext = {bits_i, hist_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_q <= '0;
    else if (!shift_i) hist_q <= '0;
    else               hist_q <= ext[EXT_W-1:P];
  end

  for (genvar k = 0; k < P; k++) begin : g_win
    assign win_o[k] = ext[HIST_W+k -: W];
  end

endmodule

// File: rtl/hs_align_match.sv
module hs_align_match #(
  parameter int         W     = 8,
  parameter int         P     = 2,
  parameter logic [W-1:0] SYNC = 8'hB8,
  localparam int        OFF_W = (P > 1) ? $clog2(P) : 1
) (
  input  logic [P-1:0][W-1:0] win_i,
  output logic                found_o,
  output logic [OFF_W-1:0]    off_o,
  output logic                err_o
);
  import hs_align_pkg::*;

  localparam int unsigned LEAD = lowest_set(64'(SYNC));

  logic [P-1:0] hit;
  logic [P-1:0] bad;

  for (genvar k = 0; k < P; k++) begin : g_cmp
    assign hit[k] = (win_i[k] == SYNC);
    assign bad[k] = win_i[k][LEAD] && !hit[k];
  end

  // earliest bit position decides
  always_comb begin
    found_o = 1'b0;
    err_o   = 1'b0;
    off_o   = '0;
    for (int k = P - 1; k >= 0; k--) begin
      if (hit[k]) begin
        found_o = 1'b1;
        err_o   = 1'b0;
        off_o   = OFF_W'(k);
      end else if (bad[k]) begin
        found_o = 1'b0;
        err_o   = 1'b1;
        off_o   = '0;
      end
    end
  end

endmodule

// File: rtl/hs_align_ctrl.sv
module hs_align_ctrl #(
  parameter int W     = 8,
  parameter int P     = 2,
  localparam int OFF_W = (P > 1) ? $clog2(P) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hs_en_i,
  input  logic                found_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic                err_i,
  input  logic [P-1:0][W-1:0] win_i,
  output logic [W-1:0]        byte_o,
  output logic                valid_o,
  output logic                lock_o,
  output logic                fail_o
);
  import hs_align_pkg::*;

  localparam int BEATS = W / P;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  aln_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ALN_HUNT;
      cnt_q   <= '0;
      ph_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!hs_en_i) begin
        st_q  <= ALN_HUNT;
        cnt_q <= '0;
      end else begin
        case (st_q)
          ALN_HUNT: begin
            if (found_i) begin
              st_q  <= ALN_LOCK;
              ph_q  <= off_i;
              cnt_q <= '0;
            end else if (err_i) begin
              st_q <= ALN_DROP;
            end
          end
          ALN_LOCK: begin
            if (cnt_q == CNT_W'(BEATS - 1)) begin
              valid_o <= 1'b1;
              byte_o  <= win_i[ph_q];
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= ALN_DROP;
        endcase
      end
    end
  end

  assign lock_o = (st_q == ALN_LOCK);
  assign fail_o = (st_q == ALN_DROP);

endmodule

// File: rtl/hs_sync_aligner.sv
module hs_sync_aligner #(
  parameter int           BYTE_W    = 8,
  parameter int           LANE_BITS = 2,
  parameter logic [BYTE_W-1:0] SYNC_WORD = 8'hB8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hs_en_i,
  input  logic [LANE_BITS-1:0] bits_i,
  output logic [BYTE_W-1:0]    byte_o,
  output logic                 valid_o,
  output logic                 sync_found_o,
  output logic                 sync_err_o
);
  localparam int OFF_W = (LANE_BITS > 1) ? $clog2(LANE_BITS) : 1;

  logic [LANE_BITS-1:0][BYTE_W-1:0] win;
  logic                             found;
  logic                             err;
  logic [OFF_W-1:0]                 off;

  hs_align_window #(.W(BYTE_W), .P(LANE_BITS)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (hs_en_i),
    .bits_i  (bits_i),
    .win_o   (win)
  );

  hs_align_match #(.W(BYTE_W), .P(LANE_BITS), .SYNC(SYNC_WORD)) u_match (
    .win_i   (win),
    .found_o (found),
    .off_o   (off),
    .err_o   (err)
  );

  hs_align_ctrl #(.W(BYTE_W), .P(LANE_BITS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hs_en_i (hs_en_i),
    .found_i (found),
    .off_i   (off),
    .err_i   (err),
    .win_i   (win),
    .byte_o  (byte_o),
    .valid_o (valid_o),
    .lock_o  (sync_found_o),
    .fail_o  (sync_err_o)
  );

endmodule

// File: rtl/hs_sync_aligner_chk.sv
module hs_sync_aligner_chk #(
  parameter int BYTE_W    = 8,
  parameter int LANE_BITS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 hs_en_i,
  input logic [LANE_BITS-1:0] bits_i,
  input logic [BYTE_W-1:0]    byte_o,
  input logic                 valid_o,
  input logic                 sync_found_o,
  input logic                 sync_err_o
);

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!valid_o && !sync_found_o && !sync_err_o && byte_o == '0); // R1
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_found_o && sync_err_o)); // R7

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sync_found_o); // R6

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5

  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_found_o && hs_en_i) |=> sync_found_o); // R4

  AST_ERR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_err_o && hs_en_i) |=> (sync_err_o && !valid_o)); // R7

  AST_EXIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_en_i |=> (!sync_found_o && !sync_err_o && !valid_o)); // R8

endmodule

bind hs_sync_aligner hs_sync_aligner_chk #(.BYTE_W(BYTE_W), .LANE_BITS(LANE_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hs_en_i      (hs_en_i),
  .bits_i       (bits_i),
  .byte_o       (byte_o),
  .valid_o      (valid_o),
  .sync_found_o (sync_found_o),
  .sync_err_o   (sync_err_o)
);

// File: tb/hs_sync_aligner_bench.sv
module hs_sync_aligner_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hs_en_i = 1'b0;
  logic [1:0] bits_i = 2'b11;
  logic [7:0] byte_o;
  logic       valid_o, sync_found_o, sync_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit run  = 0;

  hs_sync_aligner u_hs_sync_aligner (
    .clk_i(clk_i), .rst_ni(rst_ni), .hs_en_i(hs_en_i), .bits_i(bits_i),
    .byte_o(byte_o), .valid_o(valid_o), .sync_found_o(sync_found_o),
    .sync_err_o(sync_err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // bit-serial reference model: 0 hunt, 1 locked, 2 rejected
  int       m_st = 0;
  bit [7:0] m_sr = 0;
  bit [7:0] m_acc = 0;
  int       m_cnt = 0;
  bit       m_valid = 0;
  bit [7:0] m_byte = 0;
  int       rx_count = 0;
  bit [7:0] rx_last = 0;

  always @(posedge clk_i) begin
    m_valid = 0;
    if (!rst_ni || !hs_en_i) begin
      m_st = 0; m_sr = 0; m_acc = 0; m_cnt = 0;
      if (!rst_ni) m_byte = 0;
    end else begin
      for (int j = 0; j < 2; j++) begin
        if (m_st == 0) begin
          m_sr = {bits_i[j], m_sr[7:1]};
          if (m_sr == 8'hB8) begin m_st = 1; m_cnt = 0; m_acc = 0; end
          else if (m_sr[3]) m_st = 2;
        end else if (m_st == 1) begin
          m_acc[m_cnt] = bits_i[j];
          m_cnt++;
          if (m_cnt == 8) begin m_valid = 1; m_byte = m_acc; m_cnt = 0; m_acc = 0; end
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && run) begin
      chk(m_st == 1 ? "R5 valid_o" : "R6 valid_o", valid_o, m_valid);
      if (m_valid) begin
        chk("R2 byte_o", byte_o, m_byte);
        if (valid_o) begin rx_count++; rx_last = byte_o; end
      end
      chk("R4 sync_found_o", sync_found_o, m_st == 1);
      chk("R7 sync_err_o", sync_err_o, m_st == 2);
    end
  end

  bit tx_q[$];

  task automatic push_zeros(input int n);
    for (int i = 0; i < n; i++) tx_q.push_back(1'b0);
  endtask

  task automatic push_byte(input bit [7:0] b);
    for (int i = 0; i < 8; i++) tx_q.push_back(b[i]);
  endtask

  task automatic send_bits();
    if (tx_q.size() % 2 != 0) tx_q.push_back(1'b0);
    while (tx_q.size() > 0) begin
      @(negedge clk_i);
      hs_en_i   = 1'b1;
      bits_i[0] = tx_q.pop_front();
      bits_i[1] = tx_q.pop_front();
    end
  endtask

  task automatic end_burst();
    @(negedge clk_i);
    hs_en_i = 1'b0;
    bits_i  = 2'b11;
    repeat (2) @(negedge clk_i);
    chk("R8 flags after exit", {sync_found_o, sync_err_o, valid_o}, 3'b000);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired, R5 progress got=0 exp=1");
    report();
  end

  initial begin
    int rx0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", {byte_o, valid_o, sync_found_o, sync_err_o}, 0);
    rst_ni = 1'b1;
    run = 1;
    repeat (3) @(negedge clk_i);
    chk("R8 ignored while hs low", {sync_found_o, sync_err_o}, 2'b00);

    // even leader: sync ends on bits_i[1]
    push_zeros(10); send_bits();
    @(negedge clk_i);
    chk("R3 zeros quiet", {sync_found_o, sync_err_o, valid_o}, 3'b000);
    push_byte(8'hB8); push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h01);
    rx0 = rx_count;
    send_bits(); push_zeros(2); send_bits();
    chk("R4 locked even offset", sync_found_o, 1'b1);
    end_burst();
    chk("R5 three bytes", rx_count - rx0, 3);

    // odd leader: sync ends on bits_i[0]; payload carries sync value
    push_zeros(7); push_byte(8'hB8);
    push_byte(8'hFF); push_byte(8'h00); push_byte(8'hB8); push_byte(8'h96);
    rx0 = rx_count;
    send_bits();
    end_burst();
    chk("R9 bytes after sync-valued payload", rx_count - rx0, 4);

    // no zero leader at all
    push_byte(8'hB8); push_byte(8'h5A);
    rx0 = rx_count;
    send_bits(); end_burst();
    chk("R9 last byte", rx_last, 8'h5A);
    chk("R4 immediate sync", rx_count - rx0, 1);

    // corrupt pre-leader pattern, then a real leader
    push_zeros(4); push_byte(8'h01); push_byte(8'hB8); push_byte(8'h77);
    rx0 = rx_count;
    send_bits();
    chk("R7 error held", sync_err_o, 1'b1);
    end_burst();
    chk("R6 no bytes from bad burst", rx_count - rx0, 0);

    // cut mid-byte, then a fresh burst
    push_zeros(6); push_byte(8'hB8); push_byte(8'hC3); push_zeros(4);
    tx_q.push_back(1'b1); tx_q.push_back(1'b1);
    send_bits(); end_burst();
    push_zeros(3); push_byte(8'hB8); push_byte(8'h2E);
    rx0 = rx_count;
    send_bits(); end_burst();
    chk("R8 fresh burst byte", rx_last, 8'h2E);
    chk("R8 fresh burst count", rx_count - rx0, 1);

    repeat (3) @(negedge clk_i);
    report();
  end

endmodule